// File: doc/BRIEF.md
# Parallel Bus Register Access Controller

This block lets an 8-bit host bus reach a small register bank through one data port and two active-low strobes, one for writes and one for reads. Both strobes are brought into the system clock domain and edge-detected there. A two-state sequencer decides what a write means. In the address state, a write loads the internal pointer. In the data state, a write stores a byte into the register that the pointer selects, and the pointer then steps forward. Any completed read returns the sequencer to the address state.

The lowest four addresses do not hold stored bytes. Reading them returns a frozen copy of a 32-bit live measurement input, least significant byte at address 0. The copy is refreshed on the falling edge of the read strobe in two cases: when the output-length field is zero, or when the pointer is at zero. As a result, a multi-byte value read over several accesses stays consistent even while the live input moves. The 2-bit output-length field sits in the low bits of the configuration register. It also controls how the pointer moves after each read: it holds still, steps forward, or wraps back to zero.

The host must keep the two strobes from being low together. If the block sees them low together anyway, it ignores that access and raises a sticky error flag.

Top module: `pbus_reg_ctrl`

## Requirements
- R1: After reset, `data_oe` and `coll_err` are 0, every stored register reads 0 on `cfg_regs`, the pointer is 0, the sequencer is in the address state, and the output length is 0.
- R2: In the address state, a write (taken at the rising edge of `wr_n`) loads the pointer with the low bits of `data_in` and moves the sequencer to the data state. In the data state, a write stores `data_in` into the register that the pointer selects.
- R3: Each data-state write increments the pointer by one, modulo the register count, so back-to-back writes fill consecutive registers.
- R4: While a read is under way, `data_out` carries the byte at the pointer and holds steady; `data_oe` is 1 only while the synchronized read strobe is low. Addresses 4 and up return the stored register.
- R5: When a read completes (rising edge of `rd_n`), the sequencer returns to the address state, so the next write loads the pointer.
- R6: With output length 0 (bits [1:0] of the register at address 4 equal 0), the pointer does not change after a read, and each read re-captures the live value.
- R7: With output length n from 1 to 3 (meaning n+1 bytes), a completed read at pointer n sets the pointer to 0, and any other completed read increments it by one.
- R8: The live value is copied on a read falling edge only when the output length is 0 or the pointer is 0. Bytes read at pointers 1 to 3 come from that copy, even if the live input has changed since.
- R9: Writes to addresses 0 to 3 leave every stored register unchanged.
- R10: If both synchronized strobes are low together, the access is ignored (no pointer, state, register or output change), and `coll_err` goes to 1 and stays 1 until reset.
- R11: The live value is ordered least significant byte first: address k returns bits [8k+7:8k].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_n | input | 1 | Active-low write strobe |
| rd_n | input | 1 | Active-low read strobe |
| data_in | input | 8 | Data from the bus |
| data_out | output | 8 | Data driven to the bus during a read |
| data_oe | output | 1 | Output enable for the bus driver; 0 means tri-state |
| live_value | input | 32 | Live measurement word to be frozen and read out |
| coll_err | output | 1 | Sticky flag raised when both strobes are seen low |
| cfg_regs | output | 32 | Stored registers 4 to 7, register 4 in bits [7:0] |

## Verification
Two functions can land in the same cycle: the read falling edge that refreshes the live-value copy, and the selection of the byte being read. The bench provokes this by pointing at address 0, or at any address with output length 0, while the live input has just been changed. It judges the result by requiring that the byte returned is the new live byte. It then changes the live input again and reads the upper bytes, which must come from the old copy. A second overlap is forced by pulling both strobes low on the same clock, with a byte on the bus that would move the pointer if it were accepted; the next writes reveal whether anything moved.

// File: rtl/pbus_pkg.sv
package pbus_pkg;
  typedef enum logic {
    ST_ADDR = 1'b0,
    ST_DATA = 1'b1
  } acc_state_e;

  localparam int VAL_BYTES = 4;
  localparam int OLEN_W    = 2;
  localparam int BYTE_W    = 8;
endpackage

// File: rtl/pbus_strobe_sync.sv
module pbus_strobe_sync #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_n,
  input  logic          rd_n,
  input  logic [DW-1:0] din,
  output logic          wr_ev,
  output logic          rd_fall_ev,
  output logic          rd_rise_ev,
  output logic          rd_low,
  output logic          blocked,
  output logic          coll,
  output logic [DW-1:0] wdata
);
  // index 0 is the newest sample
  logic [2:0]    wr_sh, rd_sh;
  logic [DW-1:0] d1_q, d2_q;
  logic          blk_q, blk_nxt;
  logic          s_wr, s_wr_d, s_rd, s_rd_d, both_low;

  assign s_wr   = wr_sh[1];
  assign s_wr_d = wr_sh[2];
  assign s_rd   = rd_sh[1];
  assign s_rd_d = rd_sh[2];
  assign both_low = !s_wr && !s_rd;

  always_comb begin
    blk_nxt = blk_q;
    if (both_low)         blk_nxt = 1'b1;
    else if (s_wr && s_rd) blk_nxt = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_sh <= '1;
      rd_sh <= '1;
      d1_q  <= '0;
      d2_q  <= '0;
      blk_q <= 1'b0;
    end else begin
      wr_sh <= {wr_sh[1:0], wr_n};
      rd_sh <= {rd_sh[1:0], rd_n};
      d1_q  <= din;
      d2_q  <= d1_q;
      blk_q <= blk_nxt;
    end
  end

  assign blocked    = blk_q || both_low;
  assign coll       = both_low;
  assign rd_low     = !s_rd;
  assign wr_ev      = s_wr && !s_wr_d && !blocked;
  assign rd_fall_ev = !s_rd && s_rd_d && !blocked;
  assign rd_rise_ev = s_rd && !s_rd_d && !blocked;
  assign wdata      = d2_q;
endmodule

// File: rtl/pbus_access_seq.sv
module pbus_access_seq
  import pbus_pkg::*;
#(
  parameter int AW = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_ev,
  input  logic              rd_rise_ev,
  input  logic [BYTE_W-1:0] wdata,
  input  logic [OLEN_W-1:0] outlen,
  output logic [AW-1:0]     ptr,
  output acc_state_e        st,
  output logic              reg_we
);
  acc_state_e    st_q, st_nxt;
  logic [AW-1:0] ptr_q, ptr_nxt;
  logic          we_c;

  always_comb begin
    st_nxt  = st_q;
    ptr_nxt = ptr_q;
    we_c    = 1'b0;
    if (wr_ev) begin
      if (st_q == ST_ADDR) begin
        ptr_nxt = AW'(wdata);
        st_nxt  = ST_DATA;
      end else begin
        we_c    = 1'b1;
        ptr_nxt = ptr_q + AW'(1);
      end
    end else if (rd_rise_ev) begin
      st_nxt = ST_ADDR;
      if (outlen != '0) begin
        ptr_nxt = (ptr_q == AW'(outlen)) ? '0 : ptr_q + AW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_ADDR;
      ptr_q <= '0;
    end else begin
      st_q  <= st_nxt;
      ptr_q <= ptr_nxt;
    end
  end

  assign ptr    = ptr_q;
  assign st     = st_q;
  assign reg_we = we_c;
endmodule

// File: rtl/pbus_reg_file.sv
module pbus_reg_file
  import pbus_pkg::*;
#(
  parameter int NREG     = 8,
  parameter int CFG_ADDR = 4,
  parameter int AW       = 3
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              we,
  input  logic [BYTE_W-1:0]                 wdata,
  input  logic [AW-1:0]                     ptr,
  input  logic                              rd_fall_ev,
  input  logic                              rd_low,
  input  logic                              blocked,
  input  logic [VAL_BYTES*BYTE_W-1:0]       live,
  output logic [BYTE_W-1:0]                 dout,
  output logic                              oe,
  output logic [OLEN_W-1:0]                 outlen,
  output logic [(NREG-VAL_BYTES)*BYTE_W-1:0] regs_flat
);
  localparam int VW = VAL_BYTES * BYTE_W;

  logic [BYTE_W-1:0] rf [NREG];
  logic [VW-1:0]     snap_q, snap_src;
  logic [BYTE_W-1:0] dout_q, rd_byte;
  logic              oe_q, refresh;

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    if (i < VAL_BYTES) begin : g_ro
      assign rf[i] = '0;
    end else begin : g_rw
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                   rf[i] <= '0;
        else if (we && ptr == AW'(i)) rf[i] <= wdata;
      end
      assign regs_flat[(i-VAL_BYTES)*BYTE_W +: BYTE_W] = rf[i];
    end
  end

  assign outlen   = rf[CFG_ADDR][OLEN_W-1:0];
  assign refresh  = (outlen == '0) || (ptr == '0);
  assign snap_src = refresh ? live : snap_q;

  always_comb begin
    rd_byte = '0;
    for (int i = 0; i < NREG; i++) begin
      if (ptr == AW'(i)) begin
        if (i < VAL_BYTES) rd_byte = snap_src[i*BYTE_W +: BYTE_W];
        else               rd_byte = rf[i];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      snap_q <= '0;
      dout_q <= '0;
      oe_q   <= 1'b0;
    end else begin
      if (rd_fall_ev && refresh) snap_q <= live;
      if (rd_fall_ev)            dout_q <= rd_byte;
      if (rd_fall_ev)                 oe_q <= 1'b1;
      else if (!rd_low || blocked)    oe_q <= 1'b0;
    end
  end

  assign dout = dout_q;
  assign oe   = oe_q;
endmodule

// File: rtl/pbus_reg_ctrl.sv
module pbus_reg_ctrl
  import pbus_pkg::*;
#(
  parameter int NREG     = 8,
  parameter int CFG_ADDR = 4
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               wr_n,
  input  logic                               rd_n,
  input  logic [7:0]                         data_in,
  output logic [7:0]                         data_out,
  output logic                               data_oe,
  input  logic [31:0]                        live_value,
  output logic                               coll_err,
  output logic [(NREG-VAL_BYTES)*BYTE_W-1:0] cfg_regs
);
  localparam int AW = $clog2(NREG);

  logic [1:0]        rst_sh;
  logic              rst_n_i;
  logic              wr_ev, rd_fall_ev, rd_rise_ev, rd_low, blocked, coll;
  logic [BYTE_W-1:0] wdata;
  logic [AW-1:0]     ptr;
  acc_state_e        st;
  logic              reg_we, err_q;
  logic [OLEN_W-1:0] outlen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sh <= '0;
    else        rst_sh <= {rst_sh[0], 1'b1};
  end
  assign rst_n_i = rst_sh[1];

  pbus_strobe_sync #(.DW(BYTE_W)) sync_i (
    .clk(clk), .rst_n(rst_n_i), .wr_n(wr_n), .rd_n(rd_n), .din(data_in),
    .wr_ev(wr_ev), .rd_fall_ev(rd_fall_ev), .rd_rise_ev(rd_rise_ev),
    .rd_low(rd_low), .blocked(blocked), .coll(coll), .wdata(wdata)
  );

  pbus_access_seq #(.AW(AW)) seq_i (
    .clk(clk), .rst_n(rst_n_i), .wr_ev(wr_ev), .rd_rise_ev(rd_rise_ev),
    .wdata(wdata), .outlen(outlen), .ptr(ptr), .st(st), .reg_we(reg_we)
  );

  pbus_reg_file #(.NREG(NREG), .CFG_ADDR(CFG_ADDR), .AW(AW)) rf_i (
    .clk(clk), .rst_n(rst_n_i), .we(reg_we), .wdata(wdata), .ptr(ptr),
    .rd_fall_ev(rd_fall_ev), .rd_low(rd_low), .blocked(blocked),
    .live(live_value), .dout(data_out), .oe(data_oe), .outlen(outlen),
    .regs_flat(cfg_regs)
  );

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i)  err_q <= 1'b0;
    else if (coll) err_q <= 1'b1;
  end
  assign coll_err = err_q;
endmodule

// File: rtl/pbus_reg_ctrl_sva.sv
module pbus_reg_ctrl_sva
  import pbus_pkg::*;
#(
  parameter int AW = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rd_n,
  input logic              data_oe,
  input logic [7:0]        data_out,
  input logic              coll_err,
  input logic              wr_ev,
  input logic              rd_rise_ev,
  input logic [7:0]        wdata,
  input logic [AW-1:0]     ptr,
  input acc_state_e        st,
  input logic [OLEN_W-1:0] outlen
);
  a_r2_addr_load: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ev && st == ST_ADDR) |=> (st == ST_DATA && ptr == AW'($past(wdata))));

  a_r3_ptr_step: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ev && st == ST_DATA) |=> (ptr == $past(ptr) + AW'(1)));

  a_r4_oe_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_n && $past(rd_n) && $past(rd_n, 2) && $past(rd_n, 3)) |-> !data_oe);

  a_r4_out_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (data_oe && $past(data_oe)) |-> $stable(data_out));

  a_r5_back_to_addr: assert property (@(posedge clk) disable iff (!rst_n)
    rd_rise_ev |=> st == ST_ADDR);

  a_r6_ptr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_rise_ev && outlen == '0) |=> $stable(ptr));

  a_r7_ptr_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_rise_ev && outlen != '0 && ptr == AW'(outlen)) |=> ptr == '0);

  a_r10_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    coll_err |=> coll_err);
endmodule

bind pbus_reg_ctrl pbus_reg_ctrl_sva #(.AW(AW)) chk_i (
  .clk(clk), .rst_n(rst_n_i), .rd_n(rd_n), .data_oe(data_oe),
  .data_out(data_out), .coll_err(coll_err), .wr_ev(wr_ev),
  .rd_rise_ev(rd_rise_ev), .wdata(wdata), .ptr(ptr), .st(st), .outlen(outlen)
);

// File: tb/pbus_reg_ctrl_tb_top.sv
`timescale 1ns/1ps
module pbus_reg_ctrl_tb_top;
  localparam int NREG = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_n = 1'b1, rd_n = 1'b1;
  logic [7:0]  data_in = '0;
  logic [7:0]  data_out;
  logic        data_oe, coll_err;
  logic [31:0] live_value = '0;
  logic [31:0] cfg_regs;

  int n_chk = 0, n_bad = 0;

  // bench model
  int          m_ptr = 0;
  bit          m_data_st = 1'b0;
  logic [7:0]  m_rf [NREG];
  logic [31:0] m_snap = '0;

  logic [7:0] exp_q[$];
  string      tag_q[$];
  event       smp_ev;

  always #2.5 clk = ~clk;

  pbus_reg_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .wr_n(wr_n), .rd_n(rd_n), .data_in(data_in),
    .data_out(data_out), .data_oe(data_oe), .live_value(live_value),
    .coll_err(coll_err), .cfg_regs(cfg_regs)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] m_flat();
    return {m_rf[7], m_rf[6], m_rf[5], m_rf[4]};
  endfunction

  // monitor: pops expected read bytes and compares them with the bus
  always begin
    @(smp_ev);
    if (exp_q.size() == 0) begin
      n_chk++; n_bad++;
      $display("FAIL scoreboard: actual %h expected none", data_out);
    end else begin
      chk(tag_q.pop_front(), {24'h0, data_out}, {24'h0, exp_q.pop_front()});
    end
  end

  task automatic bus_wr(input logic [7:0] v);
    data_in = v;
    @(negedge clk); wr_n = 1'b0;
    repeat (4) @(negedge clk);
    wr_n = 1'b1;
    repeat (6) @(negedge clk);
    if (!m_data_st) begin
      m_ptr = v % NREG; m_data_st = 1'b1;
    end else begin
      if (m_ptr >= 4) m_rf[m_ptr] = v;
      m_ptr = (m_ptr + 1) % NREG;
    end
  endtask

  task automatic bus_rd(input string req);
    int ol;
    logic [7:0] e;
    ol = m_rf[4][1:0];
    if (ol == 0 || m_ptr == 0) m_snap = live_value;
    e = (m_ptr < 4) ? m_snap[m_ptr*8 +: 8] : m_rf[m_ptr];
    if (ol != 0) m_ptr = (m_ptr == ol) ? 0 : (m_ptr + 1) % NREG;
    m_data_st = 1'b0;
    @(negedge clk); rd_n = 1'b0;
    repeat (5) @(negedge clk);
    chk({"R4 oe during read"}, {31'h0, data_oe}, 32'h1);
    exp_q.push_back(e); tag_q.push_back(req);
    -> smp_ev;
    #0;
    rd_n = 1'b1;
    repeat (5) @(negedge clk);
    chk("R4 oe after read", {31'h0, data_oe}, 32'h0);
  endtask

  initial begin
    for (int i = 0; i < NREG; i++) m_rf[i] = '0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk("R1 oe", {31'h0, data_oe}, 32'h0);
    chk("R1 err", {31'h0, coll_err}, 32'h0);
    chk("R1 regs", cfg_regs, 32'h0);

    // R2/R3: address then two data bytes
    bus_wr(8'h05); bus_wr(8'hA5); bus_wr(8'h3C);
    chk("R2 R3 regs", cfg_regs, m_flat());
    bus_rd("R4 R6 read reg7");
    // R5: after read, write is an address
    bus_wr(8'h05);
    bus_rd("R4 R5 read reg5");
    bus_rd("R6 ptr held");

    // R7/R8/R11: four-byte value
    bus_wr(8'h04); bus_wr(8'h03);
    chk("R2 cfg", cfg_regs, m_flat());
    bus_rd("R7 step from 5");
    bus_wr(8'h00);
    live_value = 32'h11223344;
    bus_rd("R11 R8 byte0");
    live_value = 32'hDEADBEEF;
    bus_rd("R8 byte1 frozen");
    bus_rd("R8 byte2 frozen");
    bus_rd("R8 R11 byte3 frozen");
    bus_rd("R7 wrap refresh");

    // R7: two-byte value
    bus_wr(8'h04); bus_wr(8'h01);
    bus_rd("R7 step");
    bus_wr(8'h00);
    live_value = 32'hCAFE0102;
    bus_rd("R7 b0");
    live_value = 32'h99887766;
    bus_rd("R8 R7 b1");
    bus_rd("R7 wrap after b1");

    // R6: length one, address 2 refreshes each read
    bus_wr(8'h04); bus_wr(8'h00);
    bus_rd("R6 reg5");
    bus_wr(8'h02);
    live_value = 32'h00ABCDEF;
    bus_rd("R6 refresh a");
    live_value = 32'h00123456;
    bus_rd("R6 refresh b");

    // R9: writes below address 4 ignored
    bus_wr(8'h01); bus_wr(8'h77);
    chk("R9 regs", cfg_regs, m_flat());
    bus_rd("R9 R6 read addr2");

    // R10: collision ignored
    data_in = 8'h06;
    @(negedge clk); wr_n = 1'b0; rd_n = 1'b0;
    repeat (5) @(negedge clk);
    chk("R10 oe in collision", {31'h0, data_oe}, 32'h0);
    wr_n = 1'b1; rd_n = 1'b1;
    repeat (6) @(negedge clk);
    chk("R10 err set", {31'h0, coll_err}, 32'h1);
    bus_wr(8'h07); bus_wr(8'h5A);
    chk("R10 state kept", cfg_regs, m_flat());
    chk("R10 err sticky", {31'h0, coll_err}, 32'h1);
    bus_rd("R10 R6 read addr0");

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule